// File: doc/BRIEF.md
# Follow-Mode Serial Flash Byte Bridge

This block lets a processor run a serial flash one byte at a time through a five-location register window. Four byte registers hold an indirect address, and a fifth location is a data port. Once the top address register carries a special low nibble, the bridge is in follow mode. In follow mode, writes and reads of the data port turn into SPI activity, and the value held in the second address register decides what a data write does.

The bridge is itself an SPI mode-0 master. It drives the serial clock, the output data line and the active-low chip select, and it samples the input data line.

With the second address register set to 0xFD, a data write lowers chip select if it is high and then shifts the written byte out. With the second address register set to 0xFE, a data write raises chip select. It does this only after a guard time has passed since the last serial clock edge, so the flash has latched the final bit. A data read while chip select is low clocks one byte in. Repeated reads therefore poll a status byte.

Any data-port access that causes serial activity or waits on the guard holds the bus with ready low until it finishes.

Top module: `spi_follow_bridge`

## Requirements
- R1: After reset, chip select is high, the serial clock is low, the output data line is low, ready is low while no access is presented, and all four address registers read 0x00.
- R2: Bus addresses 0 to 3 are the address registers (address 3 is the top register, address 1 is the chip-select/transfer selector). They read back what was written, and an access to them completes with ready high in its first cycle.
- R3: Follow mode is on exactly when the low nibble of the register at address 3 is 0xF. Outside follow mode, a write to the data port (address 4) is ignored: no serial clock edges occur and chip select does not change. A read returns 0x00. Both complete in their first cycle.
- R4: In follow mode with address 1 equal to 0xFD, a data write lowers chip select if needed and sends the written byte on the output line, most significant bit first. The output line is stable while the serial clock is high.
- R5: In follow mode with chip select low, a data read clocks in one byte, sampling the input line on rising serial clock edges, most significant bit first. It holds the output line low while doing so. Successive reads return successive bytes of the same chip-select frame.
- R6: The serial clock idles low, toggles only while chip select is low, and each of its high phases lasts SCLK_HALF system clock cycles.
- R7: In follow mode with address 1 equal to 0xFE, a data write raises chip select no sooner than CLK_MHZ*GUARD_US cycles, and no later than twice that, after the last falling serial clock edge. The written value has no effect and no serial clock edges occur.
- R8: A chip-select raise requested while chip select is already high completes in its first cycle and leaves chip select high.
- R9: A shifting data write takes 16*SCLK_HALF+4 cycles when it must first lower chip select, and 16*SCLK_HALF+3 cycles when chip select is already low. A data read in the same frame also takes 16*SCLK_HALF+3 cycles. Ready is high only in the final cycle.
- R10: In follow mode with chip select high, a data read returns 0x00 in its first cycle without serial clock edges.
- R11: In follow mode, a data write with address 1 equal to neither 0xFE nor 0xFD is ignored. Writing address 3 with its low nibble cleared ends follow mode while its high nibble stays as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Access request, held until the cycle with ready high |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | 0..3 address registers, 4 data port |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the ready cycle |
| busReady | output | 1 | Access completes in this cycle |
| spiCsN | output | 1 | Active-low chip select |
| spiSclk | output | 1 | Serial clock, idles low |
| spiMosi | output | 1 | Serial data to the flash |
| spiMiso | input | 1 | Serial data from the flash |

## Verification
The hardest situation to reach from the ports is a chip-select raise that has to wait out the guard, because it only arises right after a byte has shifted and with the selector already switched to 0xFE. The stimulus sends a byte, rewrites address 1, and issues the raise at once. A monitor measures the gap from the last falling serial clock edge to the chip-select rise. Around that case, all 256 byte values are pushed through one frame and compared with what a slave model captured, and a run of reads is compared with the slave's computed response bytes.

// File: rtl/spi_follow_pkg.sv
package spi_follow_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CSLOW,
    ST_SHIFT,
    ST_GUARD,
    ST_DONE
  } ctrlState_e;

  typedef struct packed {
    logic arWe;
    logic csDrop;
    logic csRaise;
    logic shiftStart;
    logic txZero;
  } ctrlStrobe_t;

  localparam logic [2:0] DATA_PORT  = 3'd4;
  localparam logic [3:0] FOLLOW_NIB = 4'hF;
  localparam logic [7:0] SEL_CS_UP  = 8'hFE;
  localparam logic [7:0] SEL_XFER   = 8'hFD;

endpackage

// File: rtl/spi_follow_dp.sv
module spi_follow_dp
  import spi_follow_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int GUARD_US  = 15,
  parameter int SCLK_HALF = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctrlStrobe_t stb,
  input  logic [1:0]  regIdx,
  input  logic [7:0]  busWdata,
  input  logic        miso,
  output logic [7:0]  arRdata,
  output logic        followMode,
  output logic [7:0]  selVal,
  output logic        csN,
  output logic        sclk,
  output logic        mosi,
  output logic        busy,
  output logic        guardMet,
  output logic [7:0]  rxByte
);

  localparam int GUARD_CYC = CLK_MHZ * GUARD_US;
  localparam int GCW = $clog2(GUARD_CYC + 1);
  localparam int DCW = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;

  logic [7:0] arReg [4];

  for (genvar gi = 0; gi < 4; gi++) begin : g_ar
    logic [7:0] q;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) q <= '0;
      else if (stb.arWe && regIdx == 2'(gi)) q <= busWdata;
    end
    assign arReg[gi] = q;
  end

  assign arRdata    = arReg[regIdx];
  assign followMode = (arReg[3][3:0] == FOLLOW_NIB);
  assign selVal     = arReg[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) csN <= 1'b1;
    else if (stb.csDrop) csN <= 1'b0;
    else if (stb.csRaise) csN <= 1'b1;
  end

  logic [7:0]     shReg;
  logic [7:0]     rxReg;
  logic [2:0]     bitCnt;
  logic [DCW-1:0] divCnt;
  logic           halfTick;

  assign halfTick = (divCnt == DCW'(SCLK_HALF - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy   <= 1'b0;
      sclk   <= 1'b0;
      shReg  <= '0;
      rxReg  <= '0;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (stb.shiftStart) begin
      busy   <= 1'b1;
      sclk   <= 1'b0;
      shReg  <= stb.txZero ? 8'h00 : busWdata;
      bitCnt <= '0;
      divCnt <= '0;
    end else if (busy) begin
      if (!halfTick) begin
        divCnt <= divCnt + 1'b1;
      end else begin
        divCnt <= '0;
        if (!sclk) begin
          sclk  <= 1'b1;
          rxReg <= {rxReg[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bitCnt == 3'd7) busy <= 1'b0;
          else begin
            bitCnt <= bitCnt + 1'b1;
            shReg  <= {shReg[6:0], 1'b0};
          end
        end
      end
    end
  end

  assign mosi   = busy ? shReg[7] : 1'b0;
  assign rxByte = rxReg;

  logic [GCW-1:0] guardCnt;
  assign guardMet = (guardCnt == GCW'(GUARD_CYC));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) guardCnt <= GCW'(GUARD_CYC);
    else if (busy || stb.shiftStart) guardCnt <= '0;
    else if (!guardMet) guardCnt <= guardCnt + 1'b1;
  end

endmodule

// File: rtl/spi_follow_ctrl.sv
module spi_follow_ctrl
  import spi_follow_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busSel,
  input  logic        busWr,
  input  logic [2:0]  busAddr,
  input  logic        followMode,
  input  logic [7:0]  selVal,
  input  logic        csN,
  input  logic        busy,
  input  logic        guardMet,
  input  logic [7:0]  arRdata,
  input  logic [7:0]  rxByte,
  output ctrlStrobe_t stb,
  output logic        busReady,
  output logic [7:0]  busRdata
);

  ctrlState_e state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= stateNxt;
  end

  always_comb begin
    stb      = '0;
    stateNxt = state;
    busReady = 1'b0;
    busRdata = 8'h00;
    unique case (state)
      ST_IDLE: begin
        if (busSel) begin
          if (!busAddr[2]) begin
            busReady = 1'b1;
            busRdata = arRdata;
            stb.arWe = busWr;
          end else if (busAddr != DATA_PORT) begin
            busReady = 1'b1;
          end else if (busWr) begin
            if (followMode && selVal == SEL_CS_UP) begin
              if (csN) busReady = 1'b1;
              else stateNxt = ST_GUARD;
            end else if (followMode && selVal == SEL_XFER) begin
              if (csN) begin
                stb.csDrop = 1'b1;
                stateNxt   = ST_CSLOW;
              end else begin
                stb.shiftStart = 1'b1;
                stateNxt       = ST_SHIFT;
              end
            end else begin
              busReady = 1'b1;
            end
          end else begin
            if (followMode && !csN) begin
              stb.shiftStart = 1'b1;
              stb.txZero     = 1'b1;
              stateNxt       = ST_SHIFT;
            end else begin
              busReady = 1'b1;
            end
          end
        end
      end
      ST_CSLOW: begin
        stb.shiftStart = 1'b1;
        stateNxt       = ST_SHIFT;
      end
      ST_SHIFT: begin
        if (!busy) stateNxt = ST_DONE;
      end
      ST_GUARD: begin
        if (guardMet) begin
          stb.csRaise = 1'b1;
          stateNxt    = ST_DONE;
        end
      end
      ST_DONE: begin
        busReady = 1'b1;
        busRdata = busWr ? 8'h00 : rxByte;
        stateNxt = ST_IDLE;
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/spi_follow_bridge.sv
module spi_follow_bridge
  import spi_follow_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int GUARD_US  = 15,
  parameter int SCLK_HALF = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  output logic       busReady,
  output logic       spiCsN,
  output logic       spiSclk,
  output logic       spiMosi,
  input  logic       spiMiso
);

  ctrlStrobe_t stb;
  logic [7:0]  arRdata;
  logic        followMode;
  logic [7:0]  selVal;
  logic        busy;
  logic        guardMet;
  logic [7:0]  rxByte;

  spi_follow_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .busSel     (busSel),
    .busWr      (busWr),
    .busAddr    (busAddr),
    .followMode (followMode),
    .selVal     (selVal),
    .csN        (spiCsN),
    .busy       (busy),
    .guardMet   (guardMet),
    .arRdata    (arRdata),
    .rxByte     (rxByte),
    .stb        (stb),
    .busReady   (busReady),
    .busRdata   (busRdata)
  );

  spi_follow_dp #(
    .CLK_MHZ   (CLK_MHZ),
    .GUARD_US  (GUARD_US),
    .SCLK_HALF (SCLK_HALF)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .regIdx     (busAddr[1:0]),
    .busWdata   (busWdata),
    .miso       (spiMiso),
    .arRdata    (arRdata),
    .followMode (followMode),
    .selVal     (selVal),
    .csN        (spiCsN),
    .sclk       (spiSclk),
    .mosi       (spiMosi),
    .busy       (busy),
    .guardMet   (guardMet),
    .rxByte     (rxByte)
  );

endmodule

// File: rtl/spi_follow_bridge_chk.sv
module spi_follow_bridge_chk #(
  parameter int CLK_MHZ  = 125,
  parameter int GUARD_US = 15
) (
  input logic       clk,
  input logic       rstN,
  input logic       busSel,
  input logic [2:0] busAddr,
  input logic       busReady,
  input logic       csN,
  input logic       sclk,
  input logic       mosi,
  input logic       followMode
);

  localparam int GUARD_CYC = CLK_MHZ * GUARD_US;
  localparam int SW = $clog2(GUARD_CYC + 1) + 2;

  logic [SW-1:0] sinceFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sinceFall <= SW'(GUARD_CYC);
    else if (sclk) sinceFall <= '0;
    else if (sinceFall != {SW{1'b1}}) sinceFall <= sinceFall + 1'b1;
  end

  AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> sinceFall >= SW'(GUARD_CYC)); // R7

  AST_SCLK_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk); // R6

  AST_MOSI_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (sclk && $past(sclk)) |-> $stable(mosi)); // R4

  AST_REG_NO_STALL: assert property (@(posedge clk) disable iff (!rstN)
    (busSel && !busAddr[2]) |-> busReady); // R2

  AST_CS_HELD_OUTSIDE_FOLLOW: assert property (@(posedge clk) disable iff (!rstN)
    (!followMode && $past(!followMode)) |-> $stable(csN)); // R3

endmodule

bind spi_follow_bridge spi_follow_bridge_chk #(
  .CLK_MHZ  (CLK_MHZ),
  .GUARD_US (GUARD_US)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busAddr    (busAddr),
  .busReady   (busReady),
  .csN        (spiCsN),
  .sclk       (spiSclk),
  .mosi       (spiMosi),
  .followMode (followMode)
);

// File: tb/tb_spi_follow_bridge.sv
`timescale 1ns/1ps
module tb_spi_follow_bridge;

  localparam int H   = 2;
  localparam int MHZ = 125;
  localparam int US  = 1;
  localparam int G   = MHZ * US;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       busReady;
  logic       spiCsN;
  logic       spiSclk;
  logic       spiMosi;
  logic       spiMiso;

  always #4 clk = ~clk;

  spi_follow_bridge #(.CLK_MHZ(MHZ), .GUARD_US(US), .SCLK_HALF(H)) dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busReady(busReady),
    .spiCsN(spiCsN), .spiSclk(spiSclk), .spiMosi(spiMosi), .spiMiso(spiMiso)
  );

  int nChk = 0;
  int nFail = 0;
  bit finished = 0;

  function automatic logic [7:0] respByte(int k);
    return 8'(k * 73 + 29) ^ 8'h5A;
  endfunction

  // slave model: shifts response out on falling edges, captures MOSI on rising
  logic [7:0] sTx = 8'h00;
  logic [7:0] sRx = 8'h00;
  int sBit = 0;
  int sIdx = 0;
  int nCapt = 0;
  logic [7:0] capt [0:511];
  assign spiMiso = sTx[7];

  always @(negedge spiCsN) begin
    sTx  = respByte(0);
    sIdx = 0;
    sBit = 0;
  end
  always @(posedge spiSclk) sRx = {sRx[6:0], spiMosi};
  always @(negedge spiSclk) begin
    sBit++;
    if (sBit == 8) begin
      capt[nCapt] = sRx;
      nCapt++;
      sBit = 0;
      sIdx++;
      sTx = respByte(sIdx);
    end else begin
      sTx = {sTx[6:0], 1'b0};
    end
  end

  // line monitor sampled on the falling system clock edge
  int rises = 0;
  int highRun = 0;
  int phaseViol = 0;
  int sinceFall = 0;
  int lastGap = -1;
  logic prevSclk = 1'b0;
  logic prevCs = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      if (spiSclk && !prevSclk) rises++;
      if (spiSclk) begin
        highRun++;
        sinceFall = 0;
      end else begin
        if (prevSclk && highRun != H) phaseViol++;
        highRun = 0;
        sinceFall++;
      end
      if (spiCsN && !prevCs) lastGap = sinceFall;
      prevSclk = spiSclk;
      prevCs   = spiCsN;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic busXfer(input logic wr, input logic [2:0] a, input logic [7:0] wd,
                         output logic [7:0] rd, output int cyc);
    @(negedge clk);
    busSel = 1'b1; busWr = wr; busAddr = a; busWdata = wd;
    cyc = 0;
    forever begin
      #1;
      cyc++;
      if (busReady) begin
        rd = busRdata;
        break;
      end
      @(negedge clk);
    end
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    int cyc;
    int r0;
    int c0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(spiCsN == 1'b1, "R1 cs", spiCsN, 1);
    check(spiSclk == 1'b0, "R1 sclk", spiSclk, 0);
    check(spiMosi == 1'b0, "R1 mosi", spiMosi, 0);
    check(busReady == 1'b0, "R1 ready", busReady, 0);
    for (int a = 0; a < 4; a++) begin
      busXfer(1'b0, 3'(a), 8'h00, rd, cyc);
      check(rd == 8'h00, "R1 reg", rd, 0);
    end

    // R2 register sweep
    for (int v = 0; v < 256; v += 17) begin
      for (int a = 0; a < 3; a++) begin
        busXfer(1'b1, 3'(a), 8'(v + a), rd, cyc);
        check(cyc == 1, "R2 write stall", cyc, 1);
      end
      for (int a = 0; a < 3; a++) begin
        busXfer(1'b0, 3'(a), 8'h00, rd, cyc);
        check(rd == 8'(v + a), "R2 readback", rd, 8'(v + a));
        check(cyc == 1, "R2 read stall", cyc, 1);
      end
    end

    // R3 outside follow mode
    busXfer(1'b1, 3'd3, 8'h40, rd, cyc);
    busXfer(1'b1, 3'd1, 8'hFD, rd, cyc);
    r0 = rises;
    busXfer(1'b1, 3'd4, 8'h55, rd, cyc);
    check(cyc == 1, "R3 write stall", cyc, 1);
    check(spiCsN == 1'b1, "R3 cs", spiCsN, 1);
    busXfer(1'b0, 3'd4, 8'h00, rd, cyc);
    check(rd == 8'h00 && cyc == 1, "R3 read", rd, 0);
    check(rises == r0, "R3 no sclk", rises, r0);

    // enter follow mode
    busXfer(1'b1, 3'd3, 8'h4F, rd, cyc);

    // R10 read with CS high
    busXfer(1'b0, 3'd4, 8'h00, rd, cyc);
    check(rd == 8'h00 && cyc == 1, "R10 read", rd, 0);
    check(rises == r0, "R10 no sclk", rises, r0);

    // R8 raise while already high
    busXfer(1'b1, 3'd1, 8'hFE, rd, cyc);
    busXfer(1'b1, 3'd4, 8'h00, rd, cyc);
    check(cyc == 1, "R8 stall", cyc, 1);
    check(spiCsN == 1'b1, "R8 cs", spiCsN, 1);

    // R4 / R9 exhaustive byte sweep in one frame
    busXfer(1'b1, 3'd1, 8'hFD, rd, cyc);
    for (int b = 0; b < 256; b++) begin
      busXfer(1'b1, 3'd4, 8'(b), rd, cyc);
      if (b == 0) check(cyc == 16 * H + 4, "R9 first write cycles", cyc, 16 * H + 4);
      else check(cyc == 16 * H + 3, "R9 write cycles", cyc, 16 * H + 3);
      check(spiCsN == 1'b0, "R4 cs low", spiCsN, 0);
      check(nCapt == b + 1 && capt[b] == 8'(b), "R4 mosi byte", capt[b], b);
    end

    // R7 guarded raise right after a shift, value ignored
    busXfer(1'b1, 3'd1, 8'hFE, rd, cyc);
    r0 = rises;
    busXfer(1'b1, 3'd4, 8'hA7, rd, cyc);
    check(cyc > 1, "R7 stall", cyc, 2);
    check(spiCsN == 1'b1, "R7 cs high", spiCsN, 1);
    check(lastGap >= G + 1 && lastGap <= 2 * G, "R7 guard gap", lastGap, G + 2);
    check(rises == r0, "R7 no sclk", rises, r0);

    // R5 status polling reads
    busXfer(1'b1, 3'd1, 8'hFD, rd, cyc);
    busXfer(1'b1, 3'd4, 8'h05, rd, cyc);
    c0 = nCapt;
    for (int j = 0; j < 32; j++) begin
      busXfer(1'b0, 3'd4, 8'h00, rd, cyc);
      check(rd == respByte(1 + j), "R5 read byte", rd, respByte(1 + j));
      check(cyc == 16 * H + 3, "R9 read cycles", cyc, 16 * H + 3);
      check(capt[c0 + j] == 8'h00, "R5 mosi low", capt[c0 + j], 0);
    end
    busXfer(1'b1, 3'd1, 8'hFE, rd, cyc);
    busXfer(1'b1, 3'd4, 8'h00, rd, cyc);
    check(spiCsN == 1'b1, "R7 cs high after reads", spiCsN, 1);

    // R11 other selector value ignored, then exit follow mode
    r0 = rises;
    busXfer(1'b1, 3'd1, 8'h12, rd, cyc);
    busXfer(1'b1, 3'd4, 8'h3C, rd, cyc);
    check(cyc == 1 && spiCsN == 1'b1, "R11 other selector", cyc, 1);
    busXfer(1'b1, 3'd3, 8'h40, rd, cyc);
    busXfer(1'b1, 3'd2, 8'h00, rd, cyc);
    busXfer(1'b0, 3'd3, 8'h00, rd, cyc);
    check(rd == 8'h40, "R11 select kept", rd, 8'h40);
    busXfer(1'b1, 3'd1, 8'hFD, rd, cyc);
    busXfer(1'b1, 3'd4, 8'h99, rd, cyc);
    check(cyc == 1 && spiCsN == 1'b1, "R11 exit ignores write", spiCsN, 1);
    check(rises == r0, "R11 no sclk", rises, r0);

    // R6 clock shape totals
    check(phaseViol == 0, "R6 high phase", phaseViol, 0);
    check(rises == 8 * (256 + 1 + 32), "R6 edge count", rises, 8 * 289);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule